// File: doc/BRIEF.md
# Multi-Module Scattering Coincidence Trigger

This block makes the event selection for a segmented scintillator array read out by many modules. Each module takes the hit flags of its channels and reduces them to three mutually exclusive multiplicity lines: one channel hit, two channels hit, or three or more channels hit. A central stage then gathers the lines from all modules. It accepts the event when some module holds at least two hits, which marks a scatter inside one module. It also accepts the event when two or more modules each hold exactly one hit, which marks a scatter between modules.

An evaluation starts when `eval_i` is high at a rising edge. The whole hit vector is captured on that edge. The hit count of each module is formed in two register stages. A decision state machine then registers the verdict. The states are `ST_IDLE` (no evaluation this cycle), `ST_ACCEPT` (accept pulse with a reason code), `ST_REJECT` (reject pulse) and `ST_BLOCKED` (an acceptable event arrived while `busy_i` was high). From every state the machine moves on each clock. It goes to `ST_IDLE` when no evaluation is present, to `ST_ACCEPT` on an acceptable event with `busy_i` low, to `ST_BLOCKED` on an acceptable event with `busy_i` high, and to `ST_REJECT` otherwise. A saturating counter records the number of accepts that were blocked.

Top module: `coinc_trigger`

## Requirements
- R1: Module `m` owns bits `hits_i[m*N_CH +: N_CH]`. Its hit count is classed exclusively: exactly 1 raises only the single line, exactly 2 only the pair line, 3 or more only the many line, and 0 raises none.
- R2: An evaluation in which any module counts 2 or more hits is accepted with `reason_o[0]` set.
- R3: An evaluation in which 2 or more modules each count exactly 1 hit is accepted with `reason_o[1]` set. A module with 2 or more hits does not count toward this condition.
- R4: When both conditions hold, both reason bits are set together. `reason_o` is 0 whenever `accept_o` is low.
- R5: An evaluation that meets neither condition produces a one-cycle `reject_o` pulse. `accept_o` and `reject_o` are never high together.
- R6: The verdict of an evaluation sampled at rising edge k is visible between edges k+2 and k+3, for exactly one cycle. Evaluations on consecutive cycles give consecutive verdicts in order.
- R7: With `eval_i` low, no pulse appears on `accept_o` or `reject_o`, whatever the hit inputs are.
- R8: `busy_i` is sampled at edge k+2. An acceptable evaluation that meets `busy_i` high gives no accept and no reject, and raises `blocked_cnt_o` by one. A rejected evaluation ignores `busy_i` and leaves the counter unchanged.
- R9: `blocked_cnt_o` holds at 2^CNT_W-1 once it reaches that value.
- R10: After reset, `accept_o`, `reject_o`, `reason_o` and `blocked_cnt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| eval_i | input | 1 | Starts an evaluation of `hits_i` at this edge |
| hits_i | input | N_MOD*N_CH | Channel hit flags, module-major |
| busy_i | input | 1 | Blocks accept pulses while high |
| accept_o | output | 1 | One-cycle accept pulse |
| reject_o | output | 1 | One-cycle reject pulse |
| reason_o | output | 2 | bit0 intra-module pair or many, bit1 two-module singles |
| blocked_cnt_o | output | CNT_W | Saturating count of blocked accepts |

## Verification
The hardest condition to reach is counter saturation. It needs 65535 blocked accepts before the holding behaviour can show. The stimulus reaches it by streaming an acceptable event on every cycle with `busy_i` held high for more than 2^16 cycles. It then adds one more blocked event and checks that the count stays at the top value. Around this, the bench sweeps every module through hit counts from 0 to 64, and every unordered pair of modules with single hits. It also runs mixed single and pair patterns, so that each module position and each branch of the classification is exercised.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCEPT,
        ST_REJECT,
        ST_BLOCKED
    } dec_state_t;

    typedef struct packed {
        logic single;
        logic pair;
        logic many;
    } mult_lines_t;

endpackage

// File: rtl/trig_mod_class.sv
module trig_mod_class
    import trig_pkg::*;
#(
    parameter int N_CH = 64,
    parameter int GRP  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   hits_i,
    output mult_lines_t       lines_o
);
    localparam int N_GRP = N_CH / GRP;
    localparam int GW    = $clog2(GRP + 1);
    localparam int CW    = $clog2(N_CH + 1);

    logic [GW-1:0] part_d [N_GRP];
    logic [GW-1:0] part_q [N_GRP];
    logic [CW-1:0] total;
    mult_lines_t   lines_d;

    // stage 1: partial population counts per group
    for (genvar g = 0; g < N_GRP; g++) begin : g_part
        always_comb begin
            part_d[g] = '0;
            for (int b = 0; b < GRP; b++) begin
                part_d[g] = part_d[g] + GW'(hits_i[g*GRP + b]);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) part_q[g] <= '0;
            else        part_q[g] <= part_d[g];
        end
    end

    // stage 2: total and exclusive classification
    always_comb begin
        total = '0;
        for (int g = 0; g < N_GRP; g++) begin
            total = total + CW'(part_q[g]);
        end
        lines_d.single = (total == CW'(1));
        lines_d.pair   = (total == CW'(2));
        lines_d.many   = (total >= CW'(3));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lines_o <= '0;
        else        lines_o <= lines_d;
    end

    // R1: the three lines never overlap
    p_lines_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lines_o.single, lines_o.pair, lines_o.many}));

endmodule

// File: rtl/trig_central.sv
module trig_central
    import trig_pkg::*;
#(
    parameter int N_MOD = 25
) (
    input  mult_lines_t lines_i [N_MOD],
    output logic        pair_any_o,
    output logic        singles_ok_o
);
    localparam int SW = $clog2(N_MOD + 1);

    logic [SW-1:0] n_single;

    always_comb begin
        n_single   = '0;
        pair_any_o = 1'b0;
        for (int m = 0; m < N_MOD; m++) begin
            n_single   = n_single + SW'(lines_i[m].single);
            pair_any_o = pair_any_o | lines_i[m].pair | lines_i[m].many;
        end
        singles_ok_o = (n_single >= SW'(2));
    end

endmodule

// File: rtl/trig_decide.sv
module trig_decide
    import trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             pair_i,
    input  logic             singles_i,
    input  logic             busy_i,
    output logic             accept_o,
    output logic             reject_o,
    output logic [1:0]       reason_o,
    output logic [CNT_W-1:0] blocked_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    dec_state_t       state_q, state_d;
    logic [1:0]       reason_q, reason_d;
    logic [CNT_W-1:0] cnt_q;

    // next state
    always_comb begin
        state_d  = ST_IDLE;
        reason_d = 2'b00;
        if (valid_i) begin
            if (pair_i || singles_i) begin
                if (busy_i) begin
                    state_d = ST_BLOCKED;
                end else begin
                    state_d  = ST_ACCEPT;
                    reason_d = {singles_i, pair_i};
                end
            end else begin
                state_d = ST_REJECT;
            end
        end
    end

    // state register, reason and blocked counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            reason_q <= 2'b00;
            cnt_q    <= '0;
        end else begin
            state_q  <= state_d;
            reason_q <= reason_d;
            if (state_d == ST_BLOCKED && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        accept_o = 1'b0;
        reject_o = 1'b0;
        reason_o = 2'b00;
        unique case (state_q)
            ST_IDLE:    ;
            ST_ACCEPT: begin
                accept_o = 1'b1;
                reason_o = reason_q;
            end
            ST_REJECT:  reject_o = 1'b1;
            ST_BLOCKED: ;
        endcase
        blocked_cnt_o = cnt_q;
    end

    p_no_dual_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_o && reject_o));

    p_reason_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (reason_o != 2'b00));

    p_reason_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_o |-> (reason_o == 2'b00));

    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> !$past(busy_i));

    p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked_cnt_o == $past(blocked_cnt_o)) ||
        (blocked_cnt_o == CNT_W'($past(blocked_cnt_o) + CNT_W'(1))));

    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked_cnt_o == CNT_MAX) |=> (blocked_cnt_o == CNT_MAX));

endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
    import trig_pkg::*;
#(
    parameter int N_MOD = 25,
    parameter int N_CH  = 64,
    parameter int GRP   = 16,
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   eval_i,
    input  logic [N_MOD*N_CH-1:0]  hits_i,
    input  logic                   busy_i,
    output logic                   accept_o,
    output logic                   reject_o,
    output logic [1:0]             reason_o,
    output logic [CNT_W-1:0]       blocked_cnt_o
);
    mult_lines_t lines [N_MOD];
    logic        eval_q1, eval_q2;
    logic        pair_any, singles_ok;

    for (genvar m = 0; m < N_MOD; m++) begin : g_mod
        trig_mod_class #(
            .N_CH (N_CH),
            .GRP  (GRP)
        ) u_class (
            .clk     (clk),
            .rst_n   (rst_n),
            .hits_i  (hits_i[m*N_CH +: N_CH]),
            .lines_o (lines[m])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eval_q1 <= 1'b0;
            eval_q2 <= 1'b0;
        end else begin
            eval_q1 <= eval_i;
            eval_q2 <= eval_q1;
        end
    end

    trig_central #(
        .N_MOD (N_MOD)
    ) u_central (
        .lines_i      (lines),
        .pair_any_o   (pair_any),
        .singles_ok_o (singles_ok)
    );

    trig_decide #(
        .CNT_W (CNT_W)
    ) u_decide (
        .clk           (clk),
        .rst_n         (rst_n),
        .valid_i       (eval_q2),
        .pair_i        (pair_any),
        .singles_i     (singles_ok),
        .busy_i        (busy_i),
        .accept_o      (accept_o),
        .reject_o      (reject_o),
        .reason_o      (reason_o),
        .blocked_cnt_o (blocked_cnt_o)
    );

    // R6 / R7: a verdict only follows an evaluation three edges earlier
    p_verdict_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o || reject_o) |-> $past(eval_i, 3));

endmodule

// File: tb/tb_coinc_trigger.sv
module tb_coinc_trigger;
    localparam int NM = 25;
    localparam int NC = 64;
    localparam int CW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              eval_i = 1'b0;
    logic [NM*NC-1:0]  hits_i = '0;
    logic              busy_i = 1'b0;
    logic              accept_o, reject_o;
    logic [1:0]        reason_o;
    logic [CW-1:0]     blocked_cnt_o;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_cnt = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    coinc_trigger #(.N_MOD(NM), .N_CH(NC), .GRP(16), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .hits_i(hits_i),
        .busy_i(busy_i), .accept_o(accept_o), .reject_o(reject_o),
        .reason_o(reason_o), .blocked_cnt_o(blocked_cnt_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [NM*NC-1:0] build(input int cnt [NM]);
        logic [NM*NC-1:0] v = '0;
        for (int m = 0; m < NM; m++)
            for (int k = 0; k < cnt[m]; k++)
                v[m*NC + ((m*7 + k*13) % NC)] = 1'b1;
        return v;
    endfunction

    // expected verdict: returns reason bits, sets rej when rejected
    function automatic int model(input int cnt [NM], output bit rej);
        int ns = 0;
        bit pr = 1'b0;
        for (int m = 0; m < NM; m++) begin
            if (cnt[m] == 1) ns++;
            if (cnt[m] >= 2) pr = 1'b1;
        end
        rej = !(pr || ns >= 2);
        return {30'd0, (ns >= 2), pr};
    endfunction

    task automatic check_verdict(input int cnt [NM], input bit busy, input string req);
        bit rej;
        int rsn = model(cnt, rej);
        bit blk = busy && !rej;
        if (blk) exp_cnt = (exp_cnt < 65535) ? exp_cnt + 1 : 65535;
        chk(accept_o == (!rej && !blk), {req, " accept"}, accept_o, !rej && !blk);
        chk(reject_o == rej, {req, " reject"}, reject_o, rej);
        chk(reason_o == ((rej || blk) ? 0 : rsn), {req, " reason"}, reason_o,
            (rej || blk) ? 0 : rsn);
        chk(blocked_cnt_o == exp_cnt, {req, " blocked count"}, blocked_cnt_o, exp_cnt);
    endtask

    task automatic run_eval(input int cnt [NM], input bit busy, input string req);
        @(negedge clk);
        hits_i = build(cnt);
        eval_i = 1'b1;
        busy_i = busy;
        @(negedge clk);
        eval_i = 1'b0;
        hits_i = '0;
        @(negedge clk);
        @(negedge clk);
        check_verdict(cnt, busy, req);
        busy_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt [NM];
        int cnt2 [NM];
        int cnt3 [NM];
        int vals [6] = '{0, 1, 2, 3, 5, 64};

        repeat (3) @(negedge clk);
        // R10: reset state
        chk(accept_o == 0 && reject_o == 0, "R10 pulses", accept_o + reject_o, 0);
        chk(reason_o == 0, "R10 reason", reason_o, 0);
        chk(blocked_cnt_o == 0, "R10 count", blocked_cnt_o, 0);
        rst_n = 1'b1;

        // R1 / R2 / R5: one module swept through hit counts
        for (int m = 0; m < NM; m++) begin
            for (int v = 0; v < 6; v++) begin
                cnt = '{default: 0};
                cnt[m] = vals[v];
                run_eval(cnt, 1'b0, "R1 R2 R5 single module");
            end
        end

        // R3: every unordered pair of single-hit modules
        for (int i = 0; i < NM; i++) begin
            for (int j = i + 1; j < NM; j++) begin
                cnt = '{default: 0};
                cnt[i] = 1;
                cnt[j] = 1;
                run_eval(cnt, 1'b0, "R3 module pair");
            end
        end

        // R3: a pair module plus one single is not a two-single event; R4 both
        for (int i = 0; i < NM; i++) begin
            cnt = '{default: 0};
            cnt[i] = 2 + (i % 3);
            cnt[(i + 1) % NM] = 1;
            run_eval(cnt, 1'b0, "R3 pair plus one single");
            cnt[(i + 5) % NM] = 1;
            run_eval(cnt, 1'b0, "R4 both reasons");
        end
        cnt = '{default: 1};
        run_eval(cnt, 1'b0, "R3 all singles");
        cnt = '{default: 64};
        run_eval(cnt, 1'b0, "R2 all full");

        // R8: busy blocks accepts but not rejects
        cnt = '{default: 0};
        cnt[4] = 2;
        run_eval(cnt, 1'b1, "R8 blocked pair");
        cnt = '{default: 0};
        cnt[1] = 1; cnt[9] = 1;
        run_eval(cnt, 1'b1, "R8 blocked singles");
        cnt = '{default: 0};
        cnt[3] = 1;
        run_eval(cnt, 1'b1, "R8 reject under busy");

        // R6: back-to-back evaluations
        cnt = '{default: 0};  cnt[0] = 3;
        cnt2 = '{default: 0}; cnt2[7] = 1;
        cnt3 = '{default: 0}; cnt3[2] = 1; cnt3[20] = 1;
        @(negedge clk); hits_i = build(cnt);  eval_i = 1'b1;
        @(negedge clk); hits_i = build(cnt2);
        @(negedge clk); hits_i = build(cnt3);
        @(negedge clk); eval_i = 1'b0; hits_i = '0;
        check_verdict(cnt, 1'b0, "R6 stream first");
        @(negedge clk);
        check_verdict(cnt2, 1'b0, "R6 stream second");
        @(negedge clk);
        check_verdict(cnt3, 1'b0, "R6 stream third");
        @(negedge clk);
        chk(accept_o == 0 && reject_o == 0, "R6 single cycle pulse", accept_o + reject_o, 0);

        // R7: hits without eval give nothing
        @(negedge clk); hits_i = '1; eval_i = 1'b0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk(accept_o == 0 && reject_o == 0, "R7 no eval", accept_o + reject_o, 0);
        end
        hits_i = '0;

        // R9: saturation of the blocked counter
        cnt = '{default: 0};
        cnt[12] = 2;
        @(negedge clk); hits_i = build(cnt); eval_i = 1'b1; busy_i = 1'b1;
        repeat (65540) @(negedge clk);
        eval_i = 1'b0;
        repeat (3) @(negedge clk);
        busy_i = 1'b0;
        exp_cnt = 65535;
        chk(blocked_cnt_o == 16'hFFFF, "R9 saturated", blocked_cnt_o, 65535);
        run_eval(cnt, 1'b1, "R9 hold at top");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule